// File: doc/BRIEF.md
# RTC Time-of-Day Alarm Matcher

This block decides whether a wake-up alarm has come due. At every update of the timekeeping logic, a single-cycle strobe marks the end of the update. On that strobe the block compares the current hour, minute and second bytes with three programmed alarm bytes. A full match sets a sticky alarm flag. When the alarm enable is also 1, the block drives a level-sensitive interrupt request. The comparison happens only on the strobe, so changes to the time or alarm bytes between strobes have no effect.

An alarm byte whose two top bits are both 1 is a wildcard and always matches. Making bytes wildcards, starting with the hour, sets how often the alarm repeats: once a day, once an hour, once a minute or once a second. Software clears the flag with a read strobe. The block is meant to run from the always-on supply, so it keeps matching and flagging while the rest of the chip is on battery backup.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alarm_flag and alarm_irq are both 0.
- R2: alarm_flag becomes 1 in the cycle after update_done is 1, if each of the hour, minute and second bytes equals its alarm byte or that alarm byte is a wildcard.
- R3: An alarm byte with bits [7:6] equal to 2'b11 is a wildcard and matches any time byte value.
- R4: With no wildcard bytes, a match needs all three bytes equal. With only the hour wildcard, minutes and seconds must match. With hour and minute wildcards, only seconds must match. With all three wildcards, every update sets the flag.
- R5: When update_done is 0, the inputs are not compared, and alarm_flag does not change except through a clear.
- R6: alarm_irq is 1 exactly when alarm_flag is 1 and alarm_en is 1. It is level-sensitive and falls in the same cycle that alarm_en falls.
- R7: alarm_flag stays 1 until flag_rd_clr is 1. The flag is 0 in the cycle after the clear. If update_done sees a match in the same cycle as the clear, the new event wins and the flag stays 1.
- R8: An update without a match leaves alarm_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the always-on supply |
| rst_n | input | 1 | Active-low asynchronous reset |
| update_done | input | 1 | One-cycle strobe at the end of each update |
| cur_hr | input | 8 | Current hour byte |
| cur_min | input | 8 | Current minute byte |
| cur_sec | input | 8 | Current second byte |
| alm_hr | input | 8 | Hour alarm byte; bits [7:6]=11 means wildcard |
| alm_min | input | 8 | Minute alarm byte; bits [7:6]=11 means wildcard |
| alm_sec | input | 8 | Second alarm byte; bits [7:6]=11 means wildcard |
| alarm_en | input | 1 | Alarm interrupt enable |
| flag_rd_clr | input | 1 | Status read strobe that clears the flag |
| alarm_flag | output | 1 | Sticky alarm event flag |
| alarm_irq | output | 1 | Level-sensitive interrupt request |

## Verification
The only internal state is the flag bit, so any fault shows on alarm_flag one cycle after the update strobe or clear strobe that exposes it. A faulty wildcard decode appears as a missed or spurious flag on the first update whose time differs from the alarm only in the byte that should be ignored. A wrong comparison between strobes appears as a flag rising with no update. A wrong clear priority appears only when a read and a matching update arrive in the same cycle, which is why that case is tested directly.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         update_done,
  input  logic [W-1:0] cur_hr,
  input  logic [W-1:0] cur_min,
  input  logic [W-1:0] cur_sec,
  input  logic [W-1:0] alm_hr,
  input  logic [W-1:0] alm_min,
  input  logic [W-1:0] alm_sec,
  input  logic         alarm_en,
  input  logic         flag_rd_clr,
  output logic         alarm_flag,
  output logic         alarm_irq
);
  function automatic logic byte_hit(input logic [W-1:0] cur, input logic [W-1:0] alm);
    return (&alm[W-1:W-2]) || (cur == alm);
  endfunction

  logic all_hit;
  assign all_hit = byte_hit(cur_hr, alm_hr) && byte_hit(cur_min, alm_min) &&
                   byte_hit(cur_sec, alm_sec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   alarm_flag <= 1'b0;
    else if (update_done && all_hit) alarm_flag <= 1'b1;
    else if (flag_rd_clr)         alarm_flag <= 1'b0;
  end

  assign alarm_irq = alarm_flag & alarm_en;
endmodule

module rtc_alarm_match_chk (
  input logic clk,
  input logic rst_n,
  input logic update_done,
  input logic flag_rd_clr,
  input logic alarm_en,
  input logic alarm_flag,
  input logic alarm_irq
);
  // R6
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == (alarm_flag && alarm_en));
  // R5
  no_set_without_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !update_done |=> !$rose(alarm_flag));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_clr && !update_done) |=> !alarm_flag);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !flag_rd_clr) |=> alarm_flag);
  // R1
  reset_chk: assert property (@(posedge clk) !rst_n |-> !alarm_irq);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk chk_i (
  .clk(clk), .rst_n(rst_n), .update_done(update_done), .flag_rd_clr(flag_rd_clr),
  .alarm_en(alarm_en), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq));

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb_top;
  logic clk = 0, rst_n = 0, upd = 0, en = 0, clr = 0;
  logic [7:0] ch = 0, cm = 0, cs = 0, ah = 0, am = 0, as_ = 0;
  logic flag, irq;
  int checks = 0, errors = 0;
  localparam logic [7:0] DC = 8'hC0;

  always #5 clk = ~clk;

  rtc_alarm_match dut_i (.clk(clk), .rst_n(rst_n), .update_done(upd),
    .cur_hr(ch), .cur_min(cm), .cur_sec(cs), .alm_hr(ah), .alm_min(am), .alm_sec(as_),
    .alarm_en(en), .flag_rd_clr(clr), .alarm_flag(flag), .alarm_irq(irq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_clear();
    clr = 1; step(); clr = 0;
  endtask

  task automatic update(input logic [7:0] h, m, s);
    ch = h; cm = m; cs = s; upd = 1; step(); upd = 0;
  endtask

  task automatic t_reset();
    chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_daily();
    ah = 8'h07; am = 8'h30; as_ = 8'h15; en = 1;
    update(8'h07, 8'h30, 8'h14); chk("R8 near miss", flag, 0);
    update(8'h08, 8'h30, 8'h15); chk("R4 daily hour differs", flag, 0);
    update(8'h07, 8'h30, 8'h15); chk("R2 full match", flag, 1); chk("R6 irq", irq, 1);
    update(8'h07, 8'h30, 8'h16); chk("R7 sticky after miss", flag, 1);
    do_clear(); chk("R7 cleared", flag, 0); chk("R6 irq falls", irq, 0);
  endtask

  task automatic t_hourly();
    ah = DC; am = 8'h30; as_ = 8'h15;
    update(8'h11, 8'h30, 8'h15); chk("R3 R4 hourly any hour", flag, 1); do_clear();
    update(8'h11, 8'h31, 8'h15); chk("R4 hourly minute differs", flag, 0);
  endtask

  task automatic t_minute();
    ah = DC; am = 8'hFF; as_ = 8'h15;
    update(8'h03, 8'h42, 8'h15); chk("R4 minute rate", flag, 1); do_clear();
    update(8'h03, 8'h42, 8'h16); chk("R4 minute sec differs", flag, 0);
  endtask

  task automatic t_second();
    ah = DC; am = DC; as_ = 8'hC5;
    update(8'h23, 8'h59, 8'h59); chk("R4 every second", flag, 1); do_clear();
    update(8'h00, 8'h00, 8'h00); chk("R4 every second again", flag, 1); do_clear();
  endtask

  task automatic t_not_dc();
    ah = 8'h80; am = 8'h00; as_ = 8'h00;
    update(8'h05, 8'h00, 8'h00); chk("R3 10xxxxxx not wildcard", flag, 0);
  endtask

  task automatic t_no_update();
    ah = 8'h01; am = 8'h02; as_ = 8'h03;
    ch = 8'h01; cm = 8'h02; cs = 8'h03;
    repeat (3) step();
    chk("R5 no compare between updates", flag, 0);
  endtask

  task automatic t_enable();
    update(8'h01, 8'h02, 8'h03);
    en = 0; #1; chk("R6 disabled irq", irq, 0); chk("R6 flag kept", flag, 1);
    en = 1; #1; chk("R6 reenabled irq", irq, 1);
    clr = 1; upd = 1; step(); clr = 0; upd = 0;
    chk("R7 set wins over clear", flag, 1);
    do_clear(); chk("R7 clear", flag, 0);
  endtask

  initial begin
    #2; t_reset(); step(); rst_n = 1; step();
    t_reset(); t_daily(); t_hourly(); t_minute(); t_second();
    t_not_dc(); t_no_update(); t_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule